// File: doc/BRIEF.md
# Flash Reset and Ready Sequencer

This block sits inside a NOR-style flash memory and owns the active-low hardware reset pin. The pin is sampled on every clock. A low level becomes a real reset only after it has stayed low for a minimum number of cycles. When a reset is accepted, the block sends a one-cycle abort to the program/erase engine. It also holds the command state machine in array-read mode until the pin is released.

While the pin is low, both the output-drive gate and the command-accept enable are off. The ready indication uses two independent countdowns, and both must expire before ready returns. The first is a recovery delay that starts when the reset is accepted. Its length depends on whether the engine was busy at that moment. The second is a read delay that starts when the pin goes back high.

A supply-good input counts as reset held until it asserts. A release therefore cannot happen before the supply is valid. All delays are clock-cycle parameters: `MIN_LOW` for the pulse width, `REC_IDLE` and `REC_BUSY` for the recovery delay, and `READ_GAP` for the read delay.

Top module: `flash_rst_seq`

## Requirements
- R1: A reset is accepted at the `MIN_LOW`-th consecutive rising edge that samples the reset held. `eng_abort` is high after that edge. "Held" means `hw_rst_n` is 0 or `supply_ok` is 0.
- R2: A held period shorter than `MIN_LOW` edges has no lasting effect. No abort is issued, `csm_rd_force` stays 0, and `ready` stays 1 both during and after the period.
- R3: While the reset is held, `out_en` and `cmd_en` are 0 in the same cycle.
- R4: Each accepted reset gives exactly one cycle of `eng_abort`, however long the pin then stays held.
- R5: `csm_rd_force` is 1 from the accepting edge until the first edge that samples the reset released. After that edge it is 0.
- R6: The recovery delay D is `REC_BUSY` if `eng_busy` is 1 at the accepting edge, and `REC_IDLE` otherwise. Ready cannot return before edge A+D+1, where A is the accepting edge.
- R7: Let R be the first edge that samples the reset released. `ready` rises at edge max(R+`READ_GAP`, A+D+1). `out_en` and `cmd_en` equal `ready` while the reset is released.
- R8: While `supply_ok` is 0, a release of `hw_rst_n` has no effect. `ready` stays 0, and R counts from the edge that first samples `supply_ok` high.
- R9: During `rst_n` low, `ready`, `eng_abort` and `out_en` are 0, and `csm_rd_force` is 1. After `rst_n` is released with the pin high and the supply good, `ready` rises at the (`READ_GAP`+1)-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset of the block's own registers, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low, already synchronised |
| supply_ok | input | 1 | Supply valid; while 0, the reset counts as held |
| eng_busy | input | 1 | Program/erase engine is running an embedded operation |
| eng_abort | output | 1 | One-cycle abort strobe to the engine |
| csm_rd_force | output | 1 | Forces the command state machine to array-read mode |
| cmd_en | output | 1 | Command cycles are accepted |
| out_en | output | 1 | Output drivers enabled (0 means high impedance) |
| ready | output | 1 | Device ready for array reads |

## Verification
Most wrong internal states show up at the ports within one clock. A pulse counter that is off by one moves or drops the `eng_abort` pulse. A stale accept flag produces a second pulse, or makes `csm_rd_force` miss its release edge. Errors in the two countdowns, or in the busy-based choice of delay, appear only as a `ready` edge at the wrong cycle. For that reason the bench records the exact edge numbers of abort, release and ready, and compares them with the formula in R7.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

   // Counter width able to hold values 0..v
   function automatic int cnt_w(input int v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

   typedef enum logic {
      REC_SHORT = 1'b0,
      REC_LONG  = 1'b1
   } rec_sel_e;

endpackage

// File: rtl/rst_pulse_qual.sv
module rst_pulse_qual #(
   parameter int MIN_LOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic held,
   output logic accept
);
   import flash_rst_pkg::*;

   localparam int CW = cnt_w(MIN_LOW);

   initial begin : p_par_chk
      assert (MIN_LOW >= 1) else $error("MIN_LOW must be at least 1");
   end

   generate
      if (MIN_LOW == 1) begin : g_direct
         logic seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) seen_q <= 1'b0;
            else        seen_q <= held;
         end
         assign accept = held && !seen_q;
      end else begin : g_count
         localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);
         localparam logic [CW-1:0] SAT  = CW'(MIN_LOW);
         logic [CW-1:0] low_cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               low_cnt_q <= '0;
            else if (!held)           low_cnt_q <= '0;
            else if (low_cnt_q != SAT) low_cnt_q <= low_cnt_q + 1'b1;
         end
         assign accept = held && (low_cnt_q == LAST);

         // R1: acceptance only after the full width of held samples
         a_r1_width_reached: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> low_cnt_q == SAT);
      end
   endgenerate

endmodule

// File: rtl/rst_delay_cnt.sv
module rst_delay_cnt #(
   parameter int            W    = 4,
   parameter logic [W-1:0]  INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= INIT;
      else if (load)       cnt_q <= load_val;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R7: a running delay moves down by exactly one per cycle
   a_r7_steady_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq #(
   parameter int MIN_LOW  = 4,
   parameter int REC_IDLE = 6,
   parameter int REC_BUSY = 25,
   parameter int READ_GAP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_rst_n,
   input  logic supply_ok,
   input  logic eng_busy,
   output logic eng_abort,
   output logic csm_rd_force,
   output logic cmd_en,
   output logic out_en,
   output logic ready
);
   import flash_rst_pkg::*;

   localparam int RW = cnt_w(REC_BUSY);
   localparam int HW = cnt_w(READ_GAP);
   localparam logic [RW-1:0] REC_S = RW'(REC_IDLE);
   localparam logic [RW-1:0] REC_L = RW'(REC_BUSY);
   localparam logic [HW-1:0] GAP   = HW'(READ_GAP);

   initial begin : p_par_chk
      assert (REC_BUSY >= REC_IDLE) else $error("REC_BUSY below REC_IDLE");
      assert (REC_IDLE >= 0)        else $error("REC_IDLE negative");
      assert (READ_GAP >= 1)        else $error("READ_GAP must be at least 1");
   end

   logic     held, rel;
   logic     accept;
   logic     rec_zero, gap_zero;
   logic     abort_q, hold_q, pend_q;
   rec_sel_e rec_sel;
   logic [RW-1:0] rec_val;

   // supply not yet valid counts as reset held
   assign held = !hw_rst_n || !supply_ok;
   assign rel  = !held;

   rst_pulse_qual #(.MIN_LOW(MIN_LOW)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .held   (held),
      .accept (accept)
   );

   assign rec_sel = eng_busy ? REC_LONG : REC_SHORT;
   assign rec_val = (rec_sel == REC_LONG) ? REC_L : REC_S;

   rst_delay_cnt #(.W(RW), .INIT('0)) u_rec (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (rec_val),
      .zero     (rec_zero)
   );

   rst_delay_cnt #(.W(HW), .INIT(GAP)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (held),
      .load_val (GAP),
      .zero     (gap_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_q <= 1'b0;
         hold_q  <= 1'b1;
         pend_q  <= 1'b1;
      end else begin
         abort_q <= accept;
         if (accept)   hold_q <= 1'b1;
         else if (rel) hold_q <= 1'b0;
         if (accept)                             pend_q <= 1'b1;
         else if (rel && gap_zero && rec_zero)   pend_q <= 1'b0;
      end
   end

   assign eng_abort    = abort_q;
   assign csm_rd_force = hold_q;
   assign ready        = !pend_q;
   assign out_en       = ready && rel;
   assign cmd_en       = ready && rel;

   // R1: a fresh abort always follows a held sample
   a_r1_abort_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_abort) |-> $past(held));
   // R4: single-cycle strobe
   a_r4_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |=> !eng_abort);
   // R5: read mode forced together with the abort
   a_r5_force_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |-> csm_rd_force);
   // R3: no drive and no commands while held
   a_r3_quiet_when_held: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> (!out_en && !cmd_en));
   // R7: ready only returns once both delays are spent and the pin is free
   a_r7_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(rel) && $past(rec_zero) && $past(gap_zero)));

endmodule

// File: tb/flash_rst_seq_bench.sv
module flash_rst_seq_bench;
   localparam int CLK_PER  = 10;
   localparam int MIN_LOW  = 4;
   localparam int REC_IDLE = 6;
   localparam int REC_BUSY = 25;
   localparam int READ_GAP = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hw_rst_n = 1'b1;
   logic supply_ok = 1'b1;
   logic eng_busy = 1'b0;
   logic eng_abort, csm_rd_force, cmd_en, out_en, ready;

   int ecnt = 0;
   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PER/2) clk = ~clk;
   always @(posedge clk) ecnt <= ecnt + 1;

   flash_rst_seq #(
      .MIN_LOW(MIN_LOW), .REC_IDLE(REC_IDLE),
      .REC_BUSY(REC_BUSY), .READ_GAP(READ_GAP)
   ) u_flash_rst_seq (
      .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .supply_ok(supply_ok),
      .eng_busy(eng_busy), .eng_abort(eng_abort), .csm_rd_force(csm_rd_force),
      .cmd_en(cmd_en), .out_en(out_en), .ready(ready)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // R9: reset state and first ready
   task automatic t_reset_state();
      int e0, rdy;
      repeat (3) @(negedge clk);
      chk(ready == 0, "R9", "ready in reset", ready, 0);
      chk(eng_abort == 0, "R9", "abort in reset", eng_abort, 0);
      chk(out_en == 0, "R9", "out_en in reset", out_en, 0);
      chk(csm_rd_force == 1, "R9", "force in reset", csm_rd_force, 1);
      rst_n = 1'b1;
      e0 = ecnt;
      rdy = -1;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (ready) begin rdy = ecnt; break; end
      end
      chk(rdy == e0 + READ_GAP + 1, "R9", "first ready edge", rdy, e0 + READ_GAP + 1);
   endtask

   // R2: short pulse is a glitch
   task automatic t_glitch();
      int aborts = 0, bad_force = 0;
      @(negedge clk);
      eng_busy = 1'b1;
      hw_rst_n = 1'b0;
      for (int i = 1; i <= MIN_LOW - 1; i++) begin
         @(negedge clk);
         if (eng_abort) aborts++;
         if (csm_rd_force) bad_force++;
         chk(!out_en && !cmd_en, "R3", "gate during glitch", out_en, 0);
         chk(ready == 1, "R2", "ready during glitch", ready, 1);
      end
      hw_rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (eng_abort) aborts++;
         if (csm_rd_force) bad_force++;
      end
      chk(aborts == 0, "R2", "abort after glitch", aborts, 0);
      chk(bad_force == 0, "R2", "force after glitch", bad_force, 0);
      chk(ready == 1 && out_en == 1, "R2", "ready after glitch", ready, 1);
      eng_busy = 1'b0;
   endtask

   task automatic t_reset(input string name, input int low_len, input bit busy,
                          input int sup_gap);
      int e0, a_edge, r_edge, rdy, aborts, expv, d;
      a_edge = -1; rdy = -1; aborts = 0;
      @(negedge clk);
      eng_busy = busy;
      hw_rst_n = 1'b0;
      e0 = ecnt;
      for (int i = 1; i <= low_len; i++) begin
         @(negedge clk);
         if (eng_abort) begin aborts++; a_edge = ecnt; end
         chk(!out_en && !cmd_en, "R3", name, out_en + cmd_en, 0);
         chk(csm_rd_force == (i >= MIN_LOW), "R5", name, csm_rd_force,
             int'(i >= MIN_LOW));
      end
      hw_rst_n = 1'b1;
      if (sup_gap > 0) begin
         supply_ok = 1'b0;
         for (int i = 0; i < sup_gap; i++) begin
            @(negedge clk);
            if (eng_abort) aborts++;
            chk(ready == 0 && out_en == 0, "R8", name, ready, 0);
         end
         supply_ok = 1'b1;
      end
      r_edge = ecnt + 1;
      @(negedge clk);
      chk(csm_rd_force == 0, "R5", "force after release", csm_rd_force, 0);
      if (ready) rdy = ecnt;
      for (int i = 0; i < 100 && rdy < 0; i++) begin
         @(negedge clk);
         if (eng_abort) aborts++;
         if (ready) rdy = ecnt;
      end
      d = busy ? REC_BUSY : REC_IDLE;
      expv = imax(r_edge + READ_GAP, a_edge + d + 1);
      chk(aborts == 1, "R4", name, aborts, 1);
      chk(a_edge == e0 + MIN_LOW, "R1", name, a_edge, e0 + MIN_LOW);
      chk(rdy == expv, busy ? "R6" : "R7", name, rdy, expv);
      chk(out_en == 1 && cmd_en == 1, "R7", "gates follow ready", out_en, 1);
      eng_busy = 1'b0;
   endtask

   initial begin : p_watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin : p_main
      t_reset_state();
      t_glitch();
      t_reset("idle_short_hold", 5, 1'b0, 0);   // R7 recovery dominates
      t_reset("busy_reset", 5, 1'b1, 0);        // R6 long recovery
      t_reset("idle_long_hold", 20, 1'b0, 0);   // R7 read gap dominates
      t_reset("busy_long_hold", 40, 1'b1, 0);   // R4 one abort only
      t_reset("supply_gap", 6, 1'b0, 10);       // R8
      t_reset("exact_width", MIN_LOW, 1'b0, 0); // R1 boundary
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule